// File: doc/BRIEF.md
# Carrier Module Identification and Interrupt Responder

This block answers the identification, interrupt-acknowledge and memory address spaces of a carrier-bus serial module built from four channel-pair blocks. Identification reads return bytes from a fixed twelve-entry identity table. The table is stored one byte per 16-bit word, so the entry index is the byte address shifted right by one. A single 8-bit interrupt vector register can be loaded through address 1 of either the identification space or the memory space.

Each channel pair supplies its interrupt status and interrupt mask bytes. The block ANDs each status byte with its mask and reduces the result, then combines the pairs two at a time onto two interrupt lines: pairs 0 and 1 drive line 0, and pairs 2 and 3 drive line 1. An acknowledge read returns the vector. Because the lines are re-sampled from the live masked status on every clock, an acknowledge never clears a line whose cause is still pending.

Each access is one strobe, held for a single clock. Read data is registered and is valid in the cycle after the strobe.

Top module: `ipack_id_int_resp`

## Requirements
- R1: An identification read at byte address A returns entry A>>1 of the table {0x49,0x50,0x41,0x43,0xF0,0x22,0xA1,0x00,0x00,0x00,0x0C,0xCC}, with entry 0 listed first. Bit 0 of A is ignored.
- R2: An identification read whose index A>>1 is 12 or more returns 0x00.
- R3: An identification write to address 1 loads the interrupt vector from wdata. Identification writes to any other address leave the vector unchanged.
- R4: A memory-space write to address 1 loads the interrupt vector. Memory writes to other addresses leave it unchanged, and every memory read returns 0x00.
- R5: irq_out[0] equals the OR, over pairs 0 and 1, of (status AND mask) being nonzero. irq_out[1] is formed the same way from pairs 2 and 3. Both lines are registered, so each follows its inputs one clock later.
- R6: An interrupt-space read at address 0 or address 2 returns the current vector. It does not drop a line whose masked status is still nonzero.
- R7: Interrupt-space reads at any other address return 0x00. Interrupt-space writes change neither the vector nor the lines.
- R8: While rst_n is low at a clock edge, the vector, both lines and rdata are cleared to 0.
- R9: rdata is 0x00 in the cycle after a clock edge at which no read strobe was asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pair_isr | input | 32 | Interrupt status of each pair; pair p occupies bits [8p+7:8p] |
| pair_imr | input | 32 | Interrupt mask of each pair, packed the same way |
| id_rd | input | 1 | Identification-space read strobe |
| id_wr | input | 1 | Identification-space write strobe |
| int_rd | input | 1 | Interrupt-acknowledge-space read strobe |
| int_wr | input | 1 | Interrupt-space write strobe (ignored) |
| mem_rd | input | 1 | Memory-space read strobe |
| mem_wr | input | 1 | Memory-space 8-bit write strobe |
| addr | input | 8 | Byte address of the access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_out | output | 2 | Registered interrupt request lines |

## Verification
Two functions can act in the same cycle: an acknowledge read can be sampled at the very edge where the masked status of its line changes. The bench provokes this by randomizing the status and mask bytes on every cycle in which it issues a random strobe, including acknowledge reads at addresses 0 and 2. In each such cycle it checks that the line takes the value set by the status alone. In the same cycle it checks that rdata carries the vector as it stood before any write.

// File: rtl/ipid_pkg.sv
// Package: shared sizes and the identity table lookup for the responder.
// Assumes the table is small and constant; it is computed by a case function.
package ipid_pkg;
    localparam int PROM_LEN = 12;

    // Returns the identity byte for an entry index; out-of-range gives zero.
    function automatic logic [7:0] prom_byte(input int unsigned idx);
        case (idx)
            0:       prom_byte = 8'h49;
            1:       prom_byte = 8'h50;
            2:       prom_byte = 8'h41;
            3:       prom_byte = 8'h43;
            4:       prom_byte = 8'hF0;
            5:       prom_byte = 8'h22;
            6:       prom_byte = 8'hA1;
            7:       prom_byte = 8'h00;
            8:       prom_byte = 8'h00;
            9:       prom_byte = 8'h00;
            10:      prom_byte = 8'h0C;
            11:      prom_byte = 8'hCC;
            default: prom_byte = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/ipid_prom.sv
// Module: combinational identity table. Takes the word index (byte address
// without bit 0) and returns the stored byte, or zero past the end.
// Assumes: no clock; the caller registers the result.
module ipid_prom #(
    parameter int IDX_W = 7,
    parameter int DW    = 8
) (
    input  logic [IDX_W-1:0] idx,
    output logic [DW-1:0]    data
);
    import ipid_pkg::*;

    // Look up the entry; indices at or past the table length read zero.
    always_comb begin
        if (int'(idx) < PROM_LEN) data = DW'(prom_byte(int'(idx)));
        else                      data = '0;
    end
endmodule

// File: rtl/ipid_vector.sv
// Module: interrupt vector register. Loaded by an identification-space or
// memory-space write at the vector address; every other write is ignored.
// Assumes: one strobe per cycle; synchronous active-low reset to zero.
module ipid_vector #(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int VEC_ADDR = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          id_wr,
    input  logic          mem_wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] vec
);
    logic hit;

    // Decode a write aimed at the vector address in either space.
    always_comb hit = (id_wr || mem_wr) && (addr == AW'(VEC_ADDR));

    // Hold the vector, loading it on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n)   vec <= '0;
        else if (hit) vec <= wdata;
    end
endmodule

// File: rtl/ipid_irq_merge.sv
// Module: masks each pair's status, then ORs groups of adjacent pairs onto
// one registered line per group. Lines follow the live status every cycle.
// Assumes: NPAIRS is a multiple of NLINES.
module ipid_irq_merge #(
    parameter int NPAIRS = 4,
    parameter int NLINES = 2,
    parameter int DW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPAIRS*DW-1:0] isr,
    input  logic [NPAIRS*DW-1:0] imr,
    output logic [NLINES-1:0]    lines
);
    localparam int PER_LINE = NPAIRS / NLINES;

    logic [NPAIRS-1:0] pair_req;
    logic [NLINES-1:0] line_d;

    genvar p, l;
    generate
        for (p = 0; p < NPAIRS; p++) begin : g_pair
            // Reduce one pair's masked status to a single request.
            always_comb pair_req[p] = |(isr[p*DW +: DW] & imr[p*DW +: DW]);
        end
        for (l = 0; l < NLINES; l++) begin : g_line
            // OR the requests of the pairs that share this line.
            always_comb line_d[l] = |pair_req[l*PER_LINE +: PER_LINE];
        end
    endgenerate

    // Register the lines so they change only at a clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) lines <= '0;
        else        lines <= line_d;
    end
endmodule

// File: rtl/ipack_id_int_resp.sv
// Module: top of the responder. Decodes the identification, interrupt and
// memory spaces, registers read data and drives the merged interrupt lines.
// Assumes: at most one strobe per cycle, each held for one clock; if several
// read strobes coincide, identification wins over interrupt.
module ipack_id_int_resp #(
    parameter int NPAIRS   = 4,
    parameter int NLINES   = 2,
    parameter int DW       = 8,
    parameter int AW       = 8,
    parameter int VEC_ADDR = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPAIRS*DW-1:0] pair_isr,
    input  logic [NPAIRS*DW-1:0] pair_imr,
    input  logic                 id_rd,
    input  logic                 id_wr,
    input  logic                 int_rd,
    input  logic                 int_wr,
    input  logic                 mem_rd,
    input  logic                 mem_wr,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    output logic [NLINES-1:0]    irq_out
);
    localparam int IDX_W = AW - 1;

    logic [DW-1:0] prom_q;
    logic [DW-1:0] vec_q;
    logic          ack_hit;
    logic [DW-1:0] rd_d;

    ipid_prom #(.IDX_W(IDX_W), .DW(DW)) u_prom (
        .idx  (addr[AW-1:1]),
        .data (prom_q)
    );

    ipid_vector #(.AW(AW), .DW(DW), .VEC_ADDR(VEC_ADDR)) u_vec (
        .clk    (clk),
        .rst_n  (rst_n),
        .id_wr  (id_wr),
        .mem_wr (mem_wr),
        .addr   (addr),
        .wdata  (wdata),
        .vec    (vec_q)
    );

    ipid_irq_merge #(.NPAIRS(NPAIRS), .NLINES(NLINES), .DW(DW)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .isr   (pair_isr),
        .imr   (pair_imr),
        .lines (irq_out)
    );

    // Acknowledge addresses are the even addresses 0, 2, ... one per line.
    always_comb ack_hit = (addr[0] == 1'b0) && (int'(addr[AW-1:1]) < NLINES);

    // Select the read value; memory reads and interrupt writes give zero.
    always_comb begin
        if (id_rd)                rd_d = prom_q;
        else if (int_rd)          rd_d = ack_hit ? vec_q : '0;
        else if (mem_rd || int_wr) rd_d = '0;
        else                      rd_d = '0;
    end

    // Register the read data so it is valid the cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_d;
    end
endmodule

// File: rtl/ipid_checker.sv
// Module: property checker for the responder, bound to the top module.
// Assumes: the same one-strobe-per-cycle use as the design.
module ipid_checker #(
    parameter int NPAIRS = 4,
    parameter int NLINES = 2,
    parameter int DW     = 8,
    parameter int AW     = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NPAIRS*DW-1:0] pair_isr,
    input logic [NPAIRS*DW-1:0] pair_imr,
    input logic                 id_rd,
    input logic                 id_wr,
    input logic                 int_rd,
    input logic                 mem_rd,
    input logic                 mem_wr,
    input logic [AW-1:0]        addr,
    input logic [DW-1:0]        rdata,
    input logic [NLINES-1:0]    irq_out,
    input logic [DW-1:0]        vec_q
);
    logic line0_src, line1_src;

    // Reference requests for the two lines, built from the raw ports.
    always_comb begin
        line0_src = ((pair_isr[7:0] & pair_imr[7:0]) != 0) ||
                    ((pair_isr[15:8] & pair_imr[15:8]) != 0);
        line1_src = ((pair_isr[23:16] & pair_imr[23:16]) != 0) ||
                    ((pair_isr[31:24] & pair_imr[31:24]) != 0);
    end

    assert_irq_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_out[0] == $past(line0_src)) && (irq_out[1] == $past(line1_src)));

    assert_prom_tail_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rd && addr >= 8'd24) |=> rdata == '0);

    assert_mem_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !id_rd && !int_rd) |=> rdata == '0);

    assert_vec_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !((id_wr || mem_wr) && addr == 8'd1) |=> $stable(vec_q));

    assert_ack_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int_rd && !id_rd && (addr == 8'd0 || addr == 8'd2)) |=> rdata == $past(vec_q));

    assert_int_other_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_rd && !id_rd && addr != 8'd0 && addr != 8'd2) |=> rdata == '0);

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(id_rd || int_rd || mem_rd) |=> rdata == '0);

    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0 && rdata == '0 && vec_q == '0));
endmodule

bind ipack_id_int_resp ipid_checker #(
    .NPAIRS(NPAIRS), .NLINES(NLINES), .DW(DW), .AW(AW)
) u_ipid_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .pair_isr (pair_isr),
    .pair_imr (pair_imr),
    .id_rd    (id_rd),
    .id_wr    (id_wr),
    .int_rd   (int_rd),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .addr     (addr),
    .rdata    (rdata),
    .irq_out  (irq_out),
    .vec_q    (vec_q)
);

// File: tb/test_ipack_id_int_resp.sv
// Bench: directed corner cases followed by seeded random accesses, each
// checked against a reference model kept in bench functions.
module test_ipack_id_int_resp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pair_isr = '0, pair_imr = '0;
    logic        id_rd = 0, id_wr = 0, int_rd = 0, int_wr = 0, mem_rd = 0, mem_wr = 0;
    logic [7:0]  addr = '0, wdata = '0;
    logic [7:0]  rdata;
    logic [1:0]  irq_out;

    int compared = 0, mismatched = 0;
    logic [7:0] m_vec = '0;
    bit done = 0;

    always #4 clk = ~clk;

    ipack_id_int_resp i_ipack_id_int_resp (
        .clk(clk), .rst_n(rst_n), .pair_isr(pair_isr), .pair_imr(pair_imr),
        .id_rd(id_rd), .id_wr(id_wr), .int_rd(int_rd), .int_wr(int_wr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_out(irq_out)
    );

    function automatic logic [7:0] ref_prom(input int idx);
        logic [7:0] t [12] = '{8'h49, 8'h50, 8'h41, 8'h43, 8'hF0, 8'h22,
                               8'hA1, 8'h00, 8'h00, 8'h00, 8'h0C, 8'hCC};
        return (idx < 12) ? t[idx] : 8'h00;
    endfunction

    function automatic logic [1:0] ref_lines(input logic [31:0] s, input logic [31:0] m);
        logic [31:0] x = s & m;
        return {(x[23:16] != 0) || (x[31:24] != 0), (x[7:0] != 0) || (x[15:8] != 0)};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // op: 0 none, 1 id_rd, 2 id_wr, 3 int_rd, 4 int_wr, 5 mem_rd, 6 mem_wr
    task automatic step(input int op, input logic [7:0] a, input logic [7:0] d,
                        input logic [31:0] s, input logic [31:0] m, input string req);
        logic [7:0] exp_rd;
        logic [1:0] exp_ln;
        @(negedge clk);
        id_rd = (op == 1); id_wr = (op == 2); int_rd = (op == 3);
        int_wr = (op == 4); mem_rd = (op == 5); mem_wr = (op == 6);
        addr = a; wdata = d; pair_isr = s; pair_imr = m;
        exp_rd = 8'h00;
        if (op == 1) exp_rd = ref_prom(int'(a >> 1));
        if (op == 3) exp_rd = (a == 8'd0 || a == 8'd2) ? m_vec : 8'h00;
        exp_ln = ref_lines(s, m);
        @(posedge clk);
        #1;
        if ((op == 2 || op == 6) && a == 8'd1) m_vec = d;
        check({req, " rdata"}, rdata, exp_rd);
        check({req, " lines R5"}, {6'd0, irq_out}, {6'd0, exp_ln});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset rdata", rdata, 8'h00);
        check("R8 reset lines", {6'd0, irq_out}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        step(3, 8'd0, 8'h00, '0, '0, "R8 vector zero");
        // R1: every table entry, both byte lanes
        for (int i = 0; i < 24; i++) step(1, 8'(i), 8'h00, '0, '0, "R1 table");
        step(1, 8'd24, 8'h00, '0, '0, "R2 index 12");
        step(1, 8'd255, 8'h00, '0, '0, "R2 top");
        step(2, 8'd1, 8'h5A, '0, '0, "R3 load");
        step(3, 8'd0, 8'h00, '0, '0, "R3 readback ack0");
        step(2, 8'd3, 8'hEE, '0, '0, "R3 ignored write");
        step(3, 8'd2, 8'h00, '0, '0, "R3 readback ack1");
        step(6, 8'd1, 8'hA7, '0, '0, "R4 mem load");
        step(6, 8'd0, 8'h11, '0, '0, "R4 mem ignored");
        step(5, 8'd1, 8'h00, '0, '0, "R4 mem read");
        step(3, 8'd0, 8'h00, '0, '0, "R4 readback");
        step(4, 8'd1, 8'h33, 32'h0000_0001, 32'h0000_0001, "R7 int write");
        step(3, 8'd1, 8'h00, 32'h0000_0001, 32'h0000_0001, "R7 odd ack");
        step(3, 8'd4, 8'h00, '0, '0, "R7 high ack");
        step(0, 8'd0, 8'h00, 32'h0100_0000, 32'h0100_0000, "R5 pair3");
        step(0, 8'd0, 8'h00, 32'h0000_8000, 32'h0000_7FFF, "R5 masked off");
        step(3, 8'd0, 8'h00, 32'h0000_0200, 32'h0000_0200, "R6 ack pending");
        step(3, 8'd0, 8'h00, 32'h0000_0200, 32'h0000_0200, "R6 still pending");
        step(3, 8'd2, 8'h00, 32'h0004_0000, 32'h0004_0000, "R6 ack line1");
        step(0, 8'd7, 8'h00, '0, '0, "R9 idle");
        for (int n = 0; n < 3000; n++) begin
            int op = $urandom_range(0, 6);
            logic [7:0] a = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 27));
            logic [31:0] s = $urandom;
            logic [31:0] m = $urandom & $urandom & $urandom;
            step(op, a, 8'($urandom), s, m, "R1 R3 R4 R6 R7 R9 random");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule